// File: doc/BRIEF.md
# Byte Sum and Column Parity Checker

This block computes a two-part check code over a run of bytes held in a word memory of 16-bit entries. A start pulse gives it a first word address, a byte count and a packing select. The block then reads the words it needs through a read port with one cycle of latency. It adds every byte into a 16-bit sum that wraps on overflow. It also folds the bytes together with XOR into a column parity byte.

In word packing, each word gives two bytes: the high byte first, then the low byte. The count is a number of bytes, so an odd count stops after the high byte of the last word. In narrow packing, each word gives only its low byte. The sum is returned on one result port. The parity byte is returned zero-extended on a second result port.

The block holds `busy_o` high while it works. It pulses `done_o` for one cycle when both results are updated. A start is accepted only while the block is idle and the count is non-zero.

Top module: `bsp_checker`

## Requirements
- R1: `sum_o` is the sum of all processed bytes, each byte taken as an unsigned value from 0 to 255, modulo 65536. It wraps silently, with no overflow indication.
- R2: `par_o[7:0]` is the XOR of all processed bytes, so bit k is 1 exactly when an odd number of those bytes have bit k set. `par_o[15:8]` is always 0.
- R3: With `byte_mode_i` = 0 (word packing), bytes come from `count_i` divided by 2, rounded up, words. These are read at increasing consecutive addresses from `base_i`, wrapping at the address width. Bits 15:8 of each word are taken before bits 7:0.
- R4: In word packing with an odd count, the low byte (bits 7:0) of the last word read does not enter the sum or the parity.
- R5: With `byte_mode_i` = 1 (narrow packing), `count_i` words are read. Only bits 7:0 of each word are used.
- R6: A start with `count_i` = 0 causes no read, no `busy_o` and no `done_o`, and leaves `sum_o` and `par_o` unchanged.
- R7: A start while `busy_o` is high is ignored. This includes a start in the last busy cycle. The running operation completes with its own parameters and no second operation follows.
- R8: Timing. After the edge that accepts a start, `busy_o` is high for W+1 cycles, where W is the number of words read. `rd_en_o` is high for the first W of those cycles. Read data is taken on `rd_data_i` in the cycle after `rd_en_o`. When `busy_o` falls, `done_o` is high for exactly one cycle, and the new results appear on `sum_o` and `par_o` in that same cycle.
- R9: The words 6164H, 107BH and FACBH in word packing with a count of 6 give `sum_o` = 0315H and `par_o` = 005FH.
- R10: After reset, `busy_o`, `done_o` and `rd_en_o` are 0, and `sum_o` and `par_o` are 0000H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| base_i | input | AW | Address of the first word |
| count_i | input | CW | Number of bytes to process |
| byte_mode_i | input | 1 | 0: two bytes per word, 1: low byte per word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read address |
| rd_data_i | input | 16 | Memory read data, valid one cycle after the request |
| sum_o | output | 16 | Wrapping byte sum |
| par_o | output | 16 | Column parity byte in bits 7:0, bits 15:8 zero |

## Verification
Two of the block's functions can fall in the same cycle: the end of an operation and a new start request. In the cycle where `busy_o` is about to fall, `done_o` is about to pulse and a held start is still presented, so the block must not accept that start. The bench provokes this by holding `start_i` high, with different parameters, on every cycle that `busy_o` is high, and dropping it only in the cycle where `done_o` is seen. A behavioural model compares `busy_o`, `done_o`, the read requests and the results with the design on every clock. The results must belong to the first operation, and `busy_o` must stay low afterwards.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  // Sum contribution of one fetched word.
  // narrow: low byte only; both: high and low byte; else high byte only.
  function automatic logic [WORD_W-1:0] lane_sum(input logic [WORD_W-1:0] w,
                                                 input logic narrow,
                                                 input logic both);
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
    hi = {8'h00, w[15:8]};
    lo = {8'h00, w[7:0]};
    if (narrow) return lo;
    if (both) return hi + lo;
    return hi;
  endfunction

  // Parity contribution of one fetched word, same byte selection.
  function automatic logic [BYTE_W-1:0] lane_xor(input logic [WORD_W-1:0] w,
                                                 input logic narrow,
                                                 input logic both);
    if (narrow) return w[7:0];
    if (both) return w[15:8] ^ w[7:0];
    return w[15:8];
  endfunction

endpackage

// File: rtl/bsp_reader.sv
module bsp_reader #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] words_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rvalid_o
);

  logic [CW-1:0] issue_left;
  logic [AW-1:0] issue_addr;

  assign rd_en_o   = (issue_left != '0);
  assign rd_addr_o = issue_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_left <= '0;
      issue_addr <= '0;
      rvalid_o   <= 1'b0;
    end else begin
      rvalid_o <= rd_en_o;
      if (load_i) begin
        issue_left <= words_i;
        issue_addr <= base_i;
      end else if (rd_en_o) begin
        issue_left <= issue_left - 1'b1;
        issue_addr <= issue_addr + 1'b1;
      end
    end
  end

  // R7: a new operation is loaded only when no reads are outstanding
  a_r7_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> issue_left == '0);

  // R3: consecutive reads step the address by one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o && !load_i |=> !rd_en_o || (rd_addr_o == $past(rd_addr_o) + 1'b1));

endmodule

// File: rtl/bsp_fold.sv
module bsp_fold
  import bsp_pkg::*;
#(
  parameter int unsigned CW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [CW-1:0]     count_i,
  input  logic              narrow_i,
  input  logic              rvalid_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              last_o,
  output logic [WORD_W-1:0] sum_o,
  output logic [BYTE_W-1:0] par_o
);

  logic [CW-1:0]     bytes_left;
  logic [WORD_W-1:0] acc_sum;
  logic [BYTE_W-1:0] acc_par;
  logic              take_two;
  logic [CW-1:0]     taken;

  assign take_two = !narrow_i && (bytes_left >= CW'(2));
  assign taken    = take_two ? CW'(2) : CW'(1);
  assign last_o   = rvalid_i && (bytes_left == taken);
  assign sum_o    = acc_sum + lane_sum(rdata_i, narrow_i, take_two);
  assign par_o    = acc_par ^ lane_xor(rdata_i, narrow_i, take_two);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_left <= '0;
      acc_sum    <= '0;
      acc_par    <= '0;
    end else if (clear_i) begin
      bytes_left <= count_i;
      acc_sum    <= '0;
      acc_par    <= '0;
    end else if (rvalid_i) begin
      bytes_left <= bytes_left - taken;
      acc_sum    <= sum_o;
      acc_par    <= par_o;
    end
  end

  // R4/R5: no word is consumed beyond the requested byte count
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_i |-> bytes_left != '0);

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker
  import bsp_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic [CW-1:0]     count_i,
  input  logic              byte_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [WORD_W-1:0] sum_o,
  output logic [WORD_W-1:0] par_o
);

  logic              busy_q;
  logic              narrow_q;
  logic              done_q;
  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] par_q;

  // named internal events
  logic              accept;
  logic              finish;
  logic              rvalid;
  logic [CW:0]       half_words;
  logic [CW-1:0]     words;
  logic [WORD_W-1:0] fold_sum;
  logic [BYTE_W-1:0] fold_par;

  assign accept     = start_i && !busy_q && (count_i != '0);
  assign half_words = ({1'b0, count_i} + (CW+1)'(1)) >> 1;
  assign words      = byte_mode_i ? count_i : half_words[CW-1:0];

  bsp_reader #(.AW(AW), .CW(CW)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .base_i    (base_i),
    .words_i   (words),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .rvalid_o  (rvalid)
  );

  bsp_fold #(.CW(CW)) u_fold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .count_i  (count_i),
    .narrow_i (narrow_q),
    .rvalid_i (rvalid),
    .rdata_i  (rd_data_i),
    .last_o   (finish),
    .sum_o    (fold_sum),
    .par_o    (fold_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      narrow_q <= 1'b0;
      done_q   <= 1'b0;
      sum_q    <= '0;
      par_q    <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q   <= 1'b1;
        narrow_q <= byte_mode_i;
      end else if (finish) begin
        busy_q <= 1'b0;
        sum_q  <= fold_sum;
        par_q  <= {{(WORD_W-BYTE_W){1'b0}}, fold_par};
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sum_o  = sum_q;
  assign par_o  = par_q;

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: reads only while busy
  a_r8_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> busy_o);

  // R6: a zero count never starts an operation
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (count_i == '0) |=> !busy_o);

  // R6: results move only at the end of an operation
  a_r6_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(sum_o) && $stable(par_o));

  // R7: busy cannot be dropped or restarted by a start request
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !finish |=> busy_o);

  // R2: parity occupies only the low byte
  a_r2_par_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> par_o[15:8] == 8'h00);

endmodule

// File: tb/bsp_checker_test.sv
module bsp_checker_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int CW = 10;
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          byte_mode_i = 1'b0;
  logic          busy_o, done_o, rd_en_o;
  logic [AW-1:0] rd_addr_o;
  logic [15:0]   rd_data_i = '0;
  logic [15:0]   sum_o, par_o;

  logic [15:0] mem [256];

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int          m_busy = 0;
  int          m_issue = 0;
  int          m_addr = 0;
  bit          m_done = 0;
  logic [15:0] m_sum = 0;
  logic [15:0] m_par = 0;
  logic [15:0] p_sum = 0;
  logic [15:0] p_par = 0;

  bsp_checker #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .count_i(count_i), .byte_mode_i(byte_mode_i), .busy_o(busy_o),
    .done_o(done_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .sum_o(sum_o), .par_o(par_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory with one cycle of read latency
  always @(posedge clk) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: list the bytes, then sum and fold
  task automatic predict(input int base, input int n, input bit narrow);
    int q[$];
    int s;
    int x;
    int w;
    w = 0;
    while (q.size() < n) begin
      if (narrow) q.push_back(mem[(base + w) % 256] & 255);
      else begin
        q.push_back(mem[(base + w) % 256] >> 8);
        if (q.size() < n) q.push_back(mem[(base + w) % 256] & 255);
      end
      w++;
    end
    s = 0; x = 0;
    foreach (q[i]) begin
      s = (s + q[i]) % 65536;
      x = x ^ q[i];
    end
    p_sum = 16'(s);
    p_par = 16'(x);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_issue = 0; m_addr = 0; m_done = 0; m_sum = 0; m_par = 0;
    end else begin
      m_done = 0;
      if (m_issue > 0) begin m_issue--; m_addr = (m_addr + 1) % 256; end
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0) begin m_done = 1; m_sum = p_sum; m_par = p_par; end
      end else if (start_i && count_i != 0) begin
        int w;
        w = byte_mode_i ? int'(count_i) : (int'(count_i) + 1) / 2;
        m_busy = w + 1;
        m_issue = w;
        m_addr = int'(base_i);
        predict(int'(base_i), int'(count_i), byte_mode_i);
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 busy", {15'd0, busy_o}, {15'd0, m_busy > 0});
      chk("R8 done", {15'd0, done_o}, {15'd0, m_done});
      chk("R8 rd_en", {15'd0, rd_en_o}, {15'd0, m_issue > 0});
      if (m_issue > 0) chk("R3 rd_addr", {8'd0, rd_addr_o}, 16'(m_addr));
      chk("R1 sum", sum_o, m_sum);
      chk("R2 par", par_o, m_par);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic op(input int b, input int n, input bit md);
    int guard;
    @(negedge clk);
    base_i = AW'(b); count_i = CW'(n); byte_mode_i = md; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    if (n != 0) while (!done_o && guard < 3000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
    mem[16] = 16'h6164; mem[17] = 16'h107B; mem[18] = 16'hFACB;
    for (int i = 32; i < 232; i++) mem[i] = 16'hFFFF;

    repeat (3) @(negedge clk);
    chk("R10 busy", {15'd0, busy_o}, 16'd0);
    chk("R10 done", {15'd0, done_o}, 16'd0);
    chk("R10 rd_en", {15'd0, rd_en_o}, 16'd0);
    chk("R10 sum", sum_o, 16'h0000);
    chk("R10 par", par_o, 16'h0000);
    rst_n = 1'b1;

    op(16, 6, 1'b0);
    chk("R9 sum", sum_o, 16'h0315);
    chk("R9 par", par_o, 16'h005F);

    op(16, 5, 1'b0);
    chk("R4 sum odd count", sum_o, 16'h024A);
    chk("R4 par odd count", par_o, 16'h0094);

    op(16, 3, 1'b1);
    chk("R5 sum narrow", sum_o, 16'h01AA);
    chk("R5 par narrow", par_o, 16'h00D4);

    op(32, 400, 1'b0);
    chk("R1 sum wrap", sum_o, 16'h8E70);
    chk("R2 par even", par_o, 16'h0000);

    op(32, 1, 1'b0);
    chk("R3 sum single high byte", sum_o, 16'h00FF);
    chk("R2 par single", par_o, 16'h00FF);

    // R6: zero count
    @(negedge clk);
    base_i = 8'd16; count_i = '0; byte_mode_i = 1'b0; start_i = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R6 no busy", {15'd0, busy_o}, 16'd0);
      chk("R6 no read", {15'd0, rd_en_o}, 16'd0);
    end
    start_i = 1'b0;
    chk("R6 sum kept", sum_o, 16'h00FF);
    chk("R6 par kept", par_o, 16'h00FF);

    // R7: start held during the whole operation, including its last cycle
    @(negedge clk);
    base_i = 8'd16; count_i = 10'd6; byte_mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    base_i = 8'd40; count_i = 10'd9; byte_mode_i = 1'b1;
    while (busy_o) @(negedge clk);
    start_i = 1'b0;
    chk("R7 done at end", {15'd0, done_o}, 16'd1);
    chk("R7 sum first op", sum_o, 16'h0315);
    chk("R7 par first op", par_o, 16'h005F);
    repeat (4) begin
      @(negedge clk);
      chk("R7 stays idle", {15'd0, busy_o}, 16'd0);
    end

    // mixed patterns checked against the model
    for (int k = 0; k < 8; k++) begin
      op((k * 37 + 200) % 256, k * 5 + 2, k[0]);
      chk("R3/R5 mixed sum", sum_o, m_sum);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule